// File: doc/BRIEF.md
# Infrared UART Pulse Codec

This block sends and receives bytes in plain asynchronous serial framing, but puts each bit on the line in the infrared style used by serial infrared transceivers. It does not hold a level for the whole bit. A zero bit is one short pulse at the start of its bit cell, and a one bit leaves the line quiet. All bit timing comes from a 16x oversampling tick. A tick generator derives this tick from the system clock with an integer prescale and a first-stage fractional modulator. For example, a prescale of 26 with a modulation count of 1 gives 9600 bit/s from a 4 MHz clock.

Software writes a byte when `tx_ready` is high. The frame starts at once, with the pulse width set by `pulse_code`. On the receive side the transceiver output may be active-high or active-low, as selected by `rx_active_low`. The block finds the start pulse and realigns its bit windows to it. It then decodes the byte into a holding register, raises a valid flag and gives a one-cycle interrupt pulse. Configuration inputs are changed only while the block is idle or held in reset.

Top module: `irsir_codec`

## Requirements
- R1: After reset `ir_tx` is 0, `tx_ready` is 1, `rx_valid` is 0 and `rx_irq` is 0.
- R2: Tick periods are `presc` clocks, except that `mod_sel` of every 16 consecutive tick periods last `presc`+1 clocks. A bit cell is 16 ticks, so successive zero-bit pulses in a frame start exactly a multiple of 16*`presc`+`mod_sel` clocks apart. `presc` must be at least 2.
- R3: A transmit pulse lasts `pulse_code`/2+1 ticks, using integer division, so code 5 gives 3 ticks. Its length in clocks lies between that count times `presc` and that count times (`presc`+1), and with `mod_sel`=0 it is exactly that count times `presc`.
- R4: A frame is one start bit (0), eight data bits sent LSB first, and one stop bit (1). Each 0 bit gives one pulse at the start of its cell, and each 1 bit gives none.
- R5: `tx_load` is accepted only while `tx_ready` is 1. `tx_ready` falls in the cycle after an accepted load and returns to 1 at the end of the stop cell. A load while `tx_ready` is 0 is ignored and sends nothing.
- R6: With `rx_active_low`=0 a pulse on `ir_rx` is high and the idle line is low. With `rx_active_low`=1 a pulse is low and the idle line is high.
- R7: A received frame, whose bits are pulse-present = 0 and pulse-absent = 1, puts its eight data bits in `rx_data` (first bit in bit 0). It sets `rx_valid` and drives `rx_irq` high for exactly one cycle. Bit windows are placed relative to the detected start pulse, and bit timing does not depend on the phase of the sender.
- R8: `rx_read` high clears `rx_valid` in the next cycle, unless a new byte completes in that same cycle.
- R9: While no frame is being sent, `ir_tx` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| presc | input | 16 | Integer clocks per oversampling tick (at least 2) |
| mod_sel | input | 4 | Number of stretched ticks per 16 |
| pulse_code | input | 4 | Transmit pulse width code |
| rx_active_low | input | 1 | Receive pulse polarity select |
| tx_data | input | 8 | Byte to send |
| tx_load | input | 1 | Load strobe for `tx_data` |
| tx_ready | output | 1 | Transmitter free to accept a byte |
| ir_tx | output | 1 | Pulse output to the transceiver, active high |
| ir_rx | input | 1 | Pulse input from the transceiver |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | `rx_data` holds an unread byte |
| rx_read | input | 1 | Acknowledge; clears `rx_valid` |
| rx_irq | output | 1 | One-cycle pulse when a byte arrives |

## Verification
The hardest case to reach is a receive frame that is not locked to the block's own tick. In loopback every pulse edge lands a fixed few clocks after a tick, so the receive windows never see a pulse near their edges. The bench therefore also builds an active-low pulse train of its own, started at an odd clock offset, with a stretched bit period. It also issues a second load in the middle of a frame to show that the busy transmitter ignores it.

// File: rtl/irsir_pkg.sv
package irsir_pkg;

  localparam int OVS   = 16;
  localparam int OVS_W = 4;
  localparam int HALF  = OVS / 2;

  // width of a transmit pulse in oversampling ticks
  function automatic int unsigned pulse_ticks(input int unsigned code);
    return code / 2 + 1;
  endfunction

  // a tick period is stretched by one clock while the phase is below the modulation count
  function automatic logic long_tick(input logic [OVS_W-1:0] phase,
                                     input logic [OVS_W-1:0] mod_cnt);
    return phase < mod_cnt;
  endfunction

endpackage

// File: rtl/irsir_tick_gen.sv
module irsir_tick_gen
  import irsir_pkg::*;
#(
  parameter int PRESC_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PRESC_W-1:0] presc,
  input  logic [OVS_W-1:0]   mod_sel,
  output logic               tick
);

  logic [PRESC_W-1:0] cnt;
  logic [OVS_W-1:0]   phase;
  logic [PRESC_W:0]   lim;
  logic               stretch;

  assign stretch = long_tick(phase, mod_sel);
  assign lim     = {1'b0, presc} - 1'b1 + {{PRESC_W{1'b0}}, stretch};
  assign tick    = ({1'b0, cnt} == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= '0;
    end else if (tick) begin
      cnt   <= '0;
      phase <= phase + 1'b1;
    end else begin
      cnt   <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/irsir_tx.sv
module irsir_tx
  import irsir_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PL_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [PL_W-1:0]   pulse_code,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_load,
  output logic              tx_ready,
  output logic              ir_tx,
  output logic              tx_busy,
  output logic              tx_done
);

  localparam int FRAME_W = DATA_W + 2;
  localparam int BIT_W   = $clog2(FRAME_W);
  localparam int SW      = OVS_W + 1;
  localparam logic [BIT_W-1:0] LAST = BIT_W'(FRAME_W - 1);

  logic               busy;
  logic               started;
  logic [OVS_W-1:0]   sub;
  logic [BIT_W-1:0]   bitn;
  logic [FRAME_W-1:0] frame;
  logic [SW-1:0]      width_t;
  logic               accept;
  logic               cell_end;
  logic               last;

  assign width_t  = SW'(pulse_ticks(32'(pulse_code)));
  assign accept   = tx_load && !busy;
  assign cell_end = &sub;
  assign last     = (bitn == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      started <= 1'b0;
      sub     <= '0;
      bitn    <= '0;
      frame   <= '1;
    end else if (accept) begin
      busy    <= 1'b1;
      started <= 1'b0;
      sub     <= '0;
      bitn    <= '0;
      frame   <= {1'b1, tx_data, 1'b0};
    end else if (busy && tick) begin
      if (!started) begin
        started <= 1'b1;
        sub     <= '0;
      end else if (cell_end) begin
        sub   <= '0;
        frame <= {1'b1, frame[FRAME_W-1:1]};
        if (last) begin
          busy    <= 1'b0;
          started <= 1'b0;
        end else begin
          bitn <= bitn + 1'b1;
        end
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end

  assign ir_tx    = started && !frame[0] && ({1'b0, sub} < width_t);
  assign tx_ready = !busy;
  assign tx_busy  = busy;
  assign tx_done  = busy && tick && started && cell_end && last;

endmodule

// File: rtl/irsir_rx.sv
module irsir_rx
  import irsir_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx_active_low,
  input  logic              ir_rx,
  input  logic              rx_read,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_irq,
  output logic              pulse_edge,
  output logic              byte_done
);

  localparam int BIT_W = $clog2(DATA_W + 1);
  localparam logic [BIT_W-1:0] STOP_IDX = BIT_W'(DATA_W);
  localparam logic [OVS_W-1:0] LEAD_LIM = OVS_W'(HALF - 1);
  localparam logic [OVS_W-1:0] CELL_LIM = OVS_W'(OVS - 1);

  logic              s1, s2;
  logic              act, act_d;
  logic              busy;
  logic              lead;
  logic [OVS_W-1:0]  tcnt;
  logic [OVS_W-1:0]  lim;
  logic [BIT_W-1:0]  bitn;
  logic              hit;
  logic              hit_now;
  logic              win_end;
  logic [DATA_W-1:0] shreg;

  // input synchroniser and polarity
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1    <= 1'b0;
      s2    <= 1'b0;
      act_d <= 1'b1;
    end else begin
      s1    <= ir_rx;
      s2    <= s1;
      act_d <= act;
    end
  end

  assign act        = s2 ^ rx_active_low;
  assign pulse_edge = act && !act_d;
  assign hit_now    = hit || pulse_edge;
  assign lim        = lead ? LEAD_LIM : CELL_LIM;
  assign win_end    = busy && tick && (tcnt == lim);
  assign byte_done  = win_end && !lead && (bitn == STOP_IDX);

  // window sequencer: a half cell after the start pulse, then one window per bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      lead  <= 1'b0;
      tcnt  <= '0;
      bitn  <= '0;
      hit   <= 1'b0;
      shreg <= '0;
    end else if (!busy) begin
      if (pulse_edge) begin
        busy <= 1'b1;
        lead <= 1'b1;
        tcnt <= '0;
        bitn <= '0;
        hit  <= 1'b0;
      end
    end else if (win_end) begin
      tcnt <= '0;
      hit  <= 1'b0;
      if (lead) begin
        lead <= 1'b0;
      end else if (bitn == STOP_IDX) begin
        busy <= 1'b0;
      end else begin
        shreg <= {!hit_now, shreg[DATA_W-1:1]};
        bitn  <= bitn + 1'b1;
      end
    end else begin
      hit <= hit_now;
      if (tick) tcnt <= tcnt + 1'b1;
    end
  end

  // holding register and flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_valid <= 1'b0;
      rx_irq   <= 1'b0;
    end else begin
      rx_irq <= byte_done;
      if (byte_done) begin
        rx_data  <= shreg;
        rx_valid <= 1'b1;
      end else if (rx_read) begin
        rx_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/irsir_codec.sv
module irsir_codec
  import irsir_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int PRESC_W = 16,
  parameter int PL_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PRESC_W-1:0] presc,
  input  logic [OVS_W-1:0]  mod_sel,
  input  logic [PL_W-1:0]   pulse_code,
  input  logic              rx_active_low,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_load,
  output logic              tx_ready,
  output logic              ir_tx,
  input  logic              ir_rx,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_read,
  output logic              rx_irq
);

  logic tick;
  logic tx_busy;
  logic tx_done;
  logic rx_edge;
  logic rx_done;

  irsir_tick_gen #(.PRESC_W(PRESC_W)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .presc   (presc),
    .mod_sel (mod_sel),
    .tick    (tick)
  );

  irsir_tx #(.DATA_W(DATA_W), .PL_W(PL_W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .pulse_code (pulse_code),
    .tx_data    (tx_data),
    .tx_load    (tx_load),
    .tx_ready   (tx_ready),
    .ir_tx      (ir_tx),
    .tx_busy    (tx_busy),
    .tx_done    (tx_done)
  );

  irsir_rx #(.DATA_W(DATA_W)) u_rx (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick          (tick),
    .rx_active_low (rx_active_low),
    .ir_rx         (ir_rx),
    .rx_read       (rx_read),
    .rx_data       (rx_data),
    .rx_valid      (rx_valid),
    .rx_irq        (rx_irq),
    .pulse_edge    (rx_edge),
    .byte_done     (rx_done)
  );

endmodule

// File: rtl/irsir_chk.sv
module irsir_chk
  import irsir_pkg::*;
#(
  parameter int PRESC_W = 16,
  parameter int PL_W    = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick,
  input logic [PRESC_W-1:0] presc,
  input logic [PL_W-1:0]    pulse_code,
  input logic               tx_load,
  input logic               tx_ready,
  input logic               tx_busy,
  input logic               tx_done,
  input logic               ir_tx,
  input logic               rx_valid,
  input logic               rx_read,
  input logic               rx_irq,
  input logic               rx_done
);

  logic [PRESC_W+1:0] gap;
  logic               seen;
  logic [7:0]         ptick;
  int unsigned        wmax;

  assign wmax = pulse_ticks(32'(pulse_code));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap   <= '0;
      seen  <= 1'b0;
      ptick <= '0;
    end else begin
      if (tick) begin
        gap  <= '0;
        seen <= 1'b1;
      end else begin
        gap <= gap + 1'b1;
      end
      if (!ir_tx) ptick <= '0;
      else if (tick) ptick <= ptick + 1'b1;
    end
  end

  // R2
  tick_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && seen) |-> ((32'(gap) + 1 == 32'(presc)) || (32'(gap) + 1 == 32'(presc) + 1)));

  // R3
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_tx && tick) |-> (32'(ptick) < wmax));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> !ir_tx);

  // R5
  load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && tx_ready) |=> !tx_ready);

  // R5
  frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> tx_ready);

  // R7
  irq_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_valid);

  // R7
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);

  // R7
  done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> rx_irq);

  // R8
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_read && !rx_done) |=> !rx_valid);

endmodule

bind irsir_codec irsir_chk #(.PRESC_W(PRESC_W), .PL_W(PL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .presc      (presc),
  .pulse_code (pulse_code),
  .tx_load    (tx_load),
  .tx_ready   (tx_ready),
  .tx_busy    (tx_busy),
  .tx_done    (tx_done),
  .ir_tx      (ir_tx),
  .rx_valid   (rx_valid),
  .rx_read    (rx_read),
  .rx_irq     (rx_irq),
  .rx_done    (rx_done)
);

// File: tb/tb_irsir_codec.sv
module tb_irsir_codec;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {presc[39:24], mod[23:20], code[19:16], active_low[8], data[7:0]}
  localparam logic [39:0] VEC [NVEC] = '{
    {16'd4,  4'd0,  4'd5,  8'd0, 8'hA5},
    {16'd4,  4'd0,  4'd0,  8'd1, 8'h00},
    {16'd5,  4'd3,  4'd15, 8'd0, 8'hFF},
    {16'd6,  4'd0,  4'd2,  8'd1, 8'h81},
    {16'd26, 4'd1,  4'd5,  8'd0, 8'h3C},
    {16'd4,  4'd15, 4'd9,  8'd1, 8'h7E}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] presc = 16'd4;
  logic [3:0]  mod_sel = 4'd0;
  logic [3:0]  pulse_code = 4'd5;
  logic        rx_active_low = 1'b0;
  logic [7:0]  tx_data = 8'h00;
  logic        tx_load = 1'b0;
  logic        tx_ready;
  logic        ir_tx;
  logic        ir_rx;
  logic [7:0]  rx_data;
  logic        rx_valid;
  logic        rx_read = 1'b0;
  logic        rx_irq;
  logic        loop_en = 1'b1;
  logic        gen_line = 1'b0;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 1'b0;

  assign ir_rx = loop_en ? (rx_active_low ? !ir_tx : ir_tx) : gen_line;

  always #(CLK_PERIOD/2) clk = !clk;

  irsir_codec dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .presc         (presc),
    .mod_sel       (mod_sel),
    .pulse_code    (pulse_code),
    .rx_active_low (rx_active_low),
    .tx_data       (tx_data),
    .tx_load       (tx_load),
    .tx_ready      (tx_ready),
    .ir_tx         (ir_tx),
    .ir_rx         (ir_rx),
    .rx_data       (rx_data),
    .rx_valid      (rx_valid),
    .rx_read       (rx_read),
    .rx_irq        (rx_irq)
  );

  // pulse and interrupt monitor, sampled on the falling edge
  bit mon_clr = 1'b0;
  int n_pulse = 0;
  int n_irq = 0;
  int n_high = 0;
  int rise_t = 0;
  int p_start [16];
  int p_width [16];
  logic prev_tx = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (mon_clr) begin
      n_pulse = 0;
      n_irq   = 0;
      n_high  = 0;
      prev_tx = ir_tx;
    end else begin
      if (ir_tx) n_high++;
      if (ir_tx && !prev_tx) rise_t = cyc;
      if (!ir_tx && prev_tx && n_pulse < 16) begin
        p_start[n_pulse] = rise_t;
        p_width[n_pulse] = cyc - rise_t;
        n_pulse++;
      end
      prev_tx = ir_tx;
      if (rx_irq) n_irq++;
    end
  end

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(posedge clk) mon_clr = 1'b1;
    @(posedge clk) mon_clr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic load_byte(input logic [7:0] d);
    @(negedge clk);
    tx_data = d;
    tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
  endtask

  task automatic wait_ready(input int limit);
    for (int i = 0; i < limit; i++) begin
      if (tx_ready) break;
      @(negedge clk);
    end
  endtask

  task automatic read_rx();
    @(negedge clk) rx_read = 1'b1;
    @(negedge clk) rx_read = 1'b0;
  endtask

  // bench-built pulse train: 0 bits get a pulse at the start of their cell
  task automatic drive_frame(input logic [7:0] d, input int tbit, input int wclk, input bit al);
    logic [9:0] fr;
    fr = {1'b1, d, 1'b0};
    for (int k = 0; k < 10; k++) begin
      if (!fr[k]) begin
        gen_line = !al;
        repeat (wclk) @(negedge clk);
        gen_line = al;
        repeat (tbit - wclk) @(negedge clk);
      end else begin
        gen_line = al;
        repeat (tbit) @(negedge clk);
      end
    end
  endtask

  function automatic int zeros8(input logic [7:0] d);
    int z = 0;
    for (int i = 0; i < 8; i++) if (!d[i]) z++;
    return z;
  endfunction

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      report();
    end
  end

  initial begin
    logic [15:0] p;
    logic [3:0]  m;
    logic [3:0]  c;
    bit          al;
    logic [7:0]  d;
    int          w, tbit, lo, hi, off, pos;
    logic [7:0]  dec;
    bit          pos_ok;

    // R1: reset values
    repeat (3) @(negedge clk);
    check(ir_tx == 1'b0, "R1", "ir_tx in reset", int'(ir_tx), 0);
    check(tx_ready == 1'b1, "R1", "tx_ready in reset", int'(tx_ready), 1);
    check(rx_valid == 1'b0, "R1", "rx_valid in reset", int'(rx_valid), 0);
    check(rx_irq == 1'b0, "R1", "rx_irq in reset", int'(rx_irq), 0);
    rst_n = 1'b1;
    clear_mon();

    // R9: line stays quiet with nothing loaded
    repeat (300) @(negedge clk);
    check(n_high == 0, "R9", "idle ir_tx high cycles", n_high, 0);

    // table-driven loopback frames
    for (int v = 0; v < NVEC; v++) begin
      p  = VEC[v][39:24];
      m  = VEC[v][23:20];
      c  = VEC[v][19:16];
      al = VEC[v][8];
      d  = VEC[v][7:0];
      @(negedge clk) rst_n = 1'b0;
      presc = p; mod_sel = m; pulse_code = c; rx_active_low = al; loop_en = 1'b1;
      do_reset();
      clear_mon();
      w    = int'(c) / 2 + 1;
      tbit = 16 * int'(p) + int'(m);
      check(tx_ready == 1'b1, "R5", "tx_ready before load", int'(tx_ready), 1);
      load_byte(d);
      check(tx_ready == 1'b0, "R5", "tx_ready after load", int'(tx_ready), 0);
      wait_ready(12 * tbit + 200);
      repeat (4) @(negedge clk);
      check(n_pulse == 1 + zeros8(d), "R4", "pulse count", n_pulse, 1 + zeros8(d));
      dec = 8'hFF;
      pos_ok = 1'b1;
      for (int i = 0; i < n_pulse && i < 16; i++) begin
        lo = w * int'(p);
        hi = (m == 0) ? lo : w * (int'(p) + 1);
        check(p_width[i] >= lo && p_width[i] <= hi, "R3", "pulse width clocks", p_width[i], lo);
        off = p_start[i] - p_start[0];
        check(off % tbit == 0, "R2", "pulse start spacing remainder", off % tbit, 0);
        pos = off / tbit;
        if (pos >= 1 && pos <= 8) dec[pos-1] = 1'b0;
        else if (pos != 0) pos_ok = 1'b0;
      end
      check(pos_ok, "R4", "pulse outside data cells", 0, 1);
      check(dec == d, "R4", "decoded transmit byte", int'(dec), int'(d));
      check(rx_valid == 1'b1, "R7", "rx_valid after frame", int'(rx_valid), 1);
      check(rx_data == d, "R6", "loopback rx_data", int'(rx_data), int'(d));
      check(n_irq == 1, "R7", "rx_irq cycles", n_irq, 1);
      read_rx();
      check(rx_valid == 1'b0, "R8", "rx_valid after read", int'(rx_valid), 0);
    end

    // R5: a load while busy is ignored
    @(negedge clk) rst_n = 1'b0;
    presc = 16'd4; mod_sel = 4'd0; pulse_code = 4'd5; rx_active_low = 1'b0; loop_en = 1'b1;
    do_reset();
    clear_mon();
    load_byte(8'hFF);
    repeat (3 * 64) @(negedge clk);
    check(tx_ready == 1'b0, "R5", "tx_ready mid frame", int'(tx_ready), 0);
    load_byte(8'h00);
    wait_ready(12 * 64 + 200);
    repeat (12 * 64) @(negedge clk);
    check(n_pulse == 1, "R5", "pulses with ignored load", n_pulse, 1);
    check(rx_data == 8'hFF, "R5", "rx_data with ignored load", int'(rx_data), 255);
    check(n_irq == 1, "R5", "frames received with ignored load", n_irq, 1);

    // R6/R7: external active-low train, odd phase, stretched ticks
    @(negedge clk) rst_n = 1'b0;
    presc = 16'd5; mod_sel = 4'd7; pulse_code = 4'd3; rx_active_low = 1'b1;
    loop_en = 1'b0; gen_line = 1'b1;
    do_reset();
    clear_mon();
    repeat (37) @(negedge clk);
    drive_frame(8'h5A, 16 * 5 + 7, 10, 1'b1);
    repeat (20) @(negedge clk);
    check(rx_valid == 1'b1, "R7", "external rx_valid", int'(rx_valid), 1);
    check(rx_data == 8'h5A, "R6", "active-low external rx_data", int'(rx_data), 90);
    check(n_irq == 1, "R7", "external rx_irq cycles", n_irq, 1);
    check(n_high == 0, "R9", "ir_tx during receive only", n_high, 0);

    // R6: active-high external train, second byte without a read in between
    @(negedge clk) rst_n = 1'b0;
    presc = 16'd6; mod_sel = 4'd2; rx_active_low = 1'b0; gen_line = 1'b0;
    do_reset();
    clear_mon();
    repeat (53) @(negedge clk);
    drive_frame(8'hC3, 16 * 6 + 2, 6, 1'b0);
    repeat (40) @(negedge clk);
    drive_frame(8'h18, 16 * 6 + 2, 6, 1'b0);
    repeat (20) @(negedge clk);
    check(rx_data == 8'h18, "R6", "active-high second rx_data", int'(rx_data), 24);
    check(n_irq == 2, "R7", "two frames rx_irq cycles", n_irq, 2);
    read_rx();
    check(rx_valid == 1'b0, "R8", "rx_valid after read", int'(rx_valid), 0);

    finished = 1'b1;
    report();
  end

endmodule